// File: doc/BRIEF.md
# Pattern-Seeded Connectivity Address Generator

This block turns a binary input pattern into a reproducible series of RAM-neuron addresses for one network layer. The pattern is folded by exclusive-OR into an M-bit seed. A start strobe loads the seed into an M-stage linear feedback shift register, which then steps once per clock. Each register value is sent out as one address, so the same pattern always yields the same connectivity.

The feedback polynomial is maximal, so the plain register has period 2^M - 1. One extra state, zero, is spliced into the cycle, which gives a run of 2^M addresses that holds every value from 0 to 2^M - 1 exactly once. For M = 2 this covers addresses 0 to 3. A lower and an upper limit are captured when a run starts. A value outside that window is not dropped. It is replaced by the sentinel 2^(2^M - 1), a single set bit in the top position of the address, which no RAM location uses. The stream therefore always has the same length, and a wanted zero address stays distinct from a rejected value. A one-cycle done pulse closes each run.

With M = 4 and limits 0 and 10, eleven in-range addresses come out unchanged. The five values from 11 to 15 come out as the sentinel 0x8000.

Top module: `hsh_addr_hasher`

## Requirements
- R1: While reset is held and after it is released with no start, `addr_vld` and `run_done` are 0 and `addr_out` is 0.
- R2: When `start` is high at a clock edge while idle, `addr_vld` is 1 after that edge. The first address is derived from the seed, where seed bit i is the XOR of every pattern bit j with j mod M equal to i.
- R3: Each later address is the previous register value s shifted left by one. The new bit 0 is s[M-1] XOR s[M-2] XOR (1 when s[M-2:0] is all zero, else 0).
- R4: A run has exactly 2^M consecutive cycles with `addr_vld` high. Across the run, each register value from 0 to 2^M - 1 occurs exactly once.
- R5: `run_done` is high for exactly one cycle: the cycle right after the last valid address. `addr_vld` is low in that cycle.
- R6: A register value below `lo_lim` or above `hi_lim` is output as the sentinel. The sentinel is bit 2^M - 1 set and all other bits clear (0x8000 for M = 4). If `lo_lim` exceeds `hi_lim`, every address is the sentinel.
- R7: A register value inside the window, limits included, is output zero-extended and unchanged. Address zero is output as 0, not as the sentinel.
- R8: A `start` that arrives while a run is in progress, including its last valid cycle, is ignored. The run keeps its sequence and length, and no new run follows.
- R9: The limits and seed are taken only at the accepted start. Changing them mid-run has no effect, and the same pattern and limits always reproduce the same stream.
- R10: A `start` in the cycle where `run_done` is high is accepted and begins a new run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| pat_bits | input | PAT_W | Binary input pattern supplying the seed |
| lo_lim | input | M | Lowest legal address |
| hi_lim | input | M | Highest legal address |
| addr_vld | output | 1 | Address beat present |
| addr_out | output | 2^M | Address, or sentinel when out of range |
| run_done | output | 1 | One-cycle pulse after the last beat |

## Verification
The case of interest is a start strobe that lands in the same cycle as the end of a run. A strobe placed in the final valid cycle must be dropped: the bench expects a done pulse and then silence. A strobe placed in the done cycle must be taken, with a fresh 2^M-beat stream starting on the next cycle. Both cases are driven by directed tasks. Each address is compared against a model of the shift rule and of the window limits, which also changes the pattern and limits during a run to confirm that they were latched.

// File: rtl/hsh_pkg.sv
package hsh_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    // Lower feedback tap for a primitive trinomial x^M + x^(M-1) + 1.
    function automatic int tap_index(input int m);
        case (m)
            2:       return 0;
            3:       return 1;
            4:       return 2;
            default: return m - 2;
        endcase
    endfunction

endpackage

// File: rtl/hsh_seed_fold.sv
module hsh_seed_fold #(
    parameter int PAT_W = 16,
    parameter int M     = 4
) (
    input  logic [PAT_W-1:0] pat,
    output logic [M-1:0]     seed
);

    always_comb begin
        seed = '0;
        for (int j = 0; j < PAT_W; j++) begin
            seed[j % M] = seed[j % M] ^ pat[j];
        end
    end

endmodule

// File: rtl/hsh_lfsr_core.sv
module hsh_lfsr_core
    import hsh_pkg::*;
#(
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [M-1:0] seed,
    output logic [M-1:0] state
);

    localparam int TAP = tap_index(M);

    logic         fb;
    logic [M-1:0] nxt;

    // Maximal feedback, plus a zero-state splice that lengthens the cycle to 2^M.
    always_comb begin
        fb  = state[M-1] ^ state[TAP] ^ (state[M-2:0] == '0);
        nxt = {state[M-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (load) begin
            state <= seed;
        end else if (step) begin
            state <= nxt;
        end
    end

    AST_STATE_MOVES: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (state != $past(state))); // R3

endmodule

// File: rtl/hsh_range_gate.sv
module hsh_range_gate #(
    parameter int M  = 4,
    parameter int AW = 16
) (
    input  logic          en,
    input  logic [M-1:0]  raw,
    input  logic [M-1:0]  lo,
    input  logic [M-1:0]  hi,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] SENTINEL = AW'(1) << (AW - 1);

    always_comb begin
        if (!en) begin
            addr = '0;
        end else if ((raw < lo) || (raw > hi)) begin
            addr = SENTINEL;
        end else begin
            addr = AW'(raw);
        end
    end

endmodule

// File: rtl/hsh_addr_hasher.sv
module hsh_addr_hasher
    import hsh_pkg::*;
#(
    parameter int PAT_W = 16,
    parameter int M     = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [PAT_W-1:0]      pat_bits,
    input  logic [M-1:0]          lo_lim,
    input  logic [M-1:0]          hi_lim,
    output logic                  addr_vld,
    output logic [(1<<M)-1:0]     addr_out,
    output logic                  run_done
);

    localparam int SEQ_N   = (1 << M) - 1;
    localparam int RUN_LEN = 1 << M;
    localparam int ADDR_W  = SEQ_N + 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } beat_t;

    run_st_e      st_q;
    logic [M-1:0] cnt_q;
    logic [M-1:0] lo_q;
    logic [M-1:0] hi_q;
    logic         done_q;
    logic [M-1:0] seed;
    logic [M-1:0] lfsr_state;
    logic [ADDR_W-1:0] gated;
    logic         load;
    logic         step;
    logic         last_beat;
    beat_t        out_beat;

    assign load      = (st_q == ST_IDLE) && start;
    assign step      = (st_q == ST_RUN);
    assign last_beat = step && (cnt_q == M'(RUN_LEN - 1));

    hsh_seed_fold #(.PAT_W(PAT_W), .M(M)) u_fold (
        .pat  (pat_bits),
        .seed (seed)
    );

    hsh_lfsr_core #(.M(M)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .step  (step),
        .seed  (seed),
        .state (lfsr_state)
    );

    hsh_range_gate #(.M(M), .AW(ADDR_W)) u_gate (
        .en   (step),
        .raw  (lfsr_state),
        .lo   (lo_q),
        .hi   (hi_q),
        .addr (gated)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_RUN;
                        cnt_q <= '0;
                        lo_q  <= lo_lim;
                        hi_q  <= hi_lim;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_beat) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign out_beat = '{vld: step, addr: gated};
    assign addr_vld = out_beat.vld;
    assign addr_out = out_beat.addr;
    assign run_done = done_q;

    AST_VLD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && !last_beat) |=> addr_vld); // R4

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && last_beat) |=> (run_done && !addr_vld)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        run_done |=> !run_done); // R5

    AST_SENT_ALONE: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && addr_out[ADDR_W-1]) |-> (addr_out[ADDR_W-2:0] == '0)); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && start && !last_beat) |=> (addr_vld && (cnt_q == $past(cnt_q) + 1'b1))); // R8

    AST_DONE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run_done && start) |=> (addr_vld && (cnt_q == '0))); // R10

endmodule

// File: tb/tb_hsh_addr_hasher.sv
`timescale 1ns/1ps
module tb_hsh_addr_hasher;

    localparam int M      = 4;
    localparam int PAT_W  = 16;
    localparam int RUNL   = 16;
    localparam logic [15:0] SENT = 16'h8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pat_bits = '0;
    logic [3:0]  lo_lim = '0;
    logic [3:0]  hi_lim = '0;
    logic        addr_vld;
    logic [15:0] addr_out;
    logic        run_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hsh_addr_hasher #(.PAT_W(PAT_W), .M(M)) dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pat_bits (pat_bits),
        .lo_lim   (lo_lim),
        .hi_lim   (hi_lim),
        .addr_vld (addr_vld),
        .addr_out (addr_out),
        .run_done (run_done)
    );

    function automatic logic [3:0] fold(input logic [15:0] p);
        return p[3:0] ^ p[7:4] ^ p[11:8] ^ p[15:12];
    endfunction

    function automatic logic [3:0] nstep(input logic [3:0] s);
        logic b;
        b = s[3] ^ s[2] ^ (s[2:0] == 3'b000);
        return {s[2:0], b};
    endfunction

    function automatic logic [15:0] expect_addr(input logic [3:0] v, input logic [3:0] lo, input logic [3:0] hi);
        if (v < lo || v > hi) return SENT;
        return {12'h000, v};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic launch(input logic [15:0] p, input logic [3:0] lo, input logic [3:0] hi);
        pat_bits = p;
        lo_lim   = lo;
        hi_lim   = hi;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Checks one full stream; returns at the done cycle when keep_done is set.
    task automatic stream(input logic [15:0] p, input logic [3:0] lo, input logic [3:0] hi,
                          input int poke, input bit keep_done, input string tag);
        logic [3:0]  s;
        logic [15:0] seen;
        logic [15:0] e;
        s    = fold(p);
        seen = '0;
        for (int i = 0; i < RUNL; i++) begin
            e = expect_addr(s, lo, hi);
            chk(addr_vld == 1'b1, "R4", {15'b0, addr_vld}, 16'h1);
            if (i == 0)
                chk(addr_out == e, "R2", addr_out, e);
            else if (e == SENT)
                chk(addr_out == e, "R6", addr_out, e);
            else
                chk(addr_out == e, (poke >= 0) ? "R9" : "R3", addr_out, e);
            seen[s] = 1'b1;
            s = nstep(s);
            if (i == poke) begin
                start    = 1'b1;
                pat_bits = ~p;
                lo_lim   = 4'd0;
                hi_lim   = 4'd15;
            end else if (i == poke + 1) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen == 16'hFFFF, "R4", seen, 16'hFFFF);
        chk(run_done == 1'b1 && addr_vld == 1'b0, "R5", {14'b0, run_done, addr_vld}, 16'h2);
        if (!keep_done) begin
            @(negedge clk);
            chk(run_done == 1'b0 && addr_vld == 1'b0,
                (poke == RUNL - 1) ? "R8" : "R5", {14'b0, run_done, addr_vld}, 16'h0);
        end
        if (tag.len() == 0) $display("stream done");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(addr_vld == 1'b0 && run_done == 1'b0 && addr_out == 16'h0, "R1", addr_out, 16'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(addr_vld == 1'b0 && run_done == 1'b0 && addr_out == 16'h0, "R1", addr_out, 16'h0);
    endtask

    task automatic t_full_range();
        launch(16'h0000, 4'd0, 4'd15);
        stream(16'h0000, 4'd0, 4'd15, -1, 1'b0, "R7");
        launch(16'h1248, 4'd0, 4'd15);
        stream(16'h1248, 4'd0, 4'd15, -1, 1'b0, "R3");
    endtask

    task automatic t_upper_limit();
        int inr;
        inr = 0;
        launch(16'hA5C7, 4'd0, 4'd10);
        for (int i = 0; i < RUNL; i++) begin
            if (addr_out != SENT && addr_vld) inr++;
            if (addr_vld && addr_out == 16'h0)
                chk(1'b1, "R7", addr_out, 16'h0);
            if (i < RUNL - 1) @(negedge clk);
        end
        chk(inr == 11, "R7", 16'(inr), 16'd11);
        @(negedge clk);
        chk(run_done == 1'b1, "R5", {15'b0, run_done}, 16'h1);
        @(negedge clk);
        launch(16'hA5C7, 4'd0, 4'd10);
        stream(16'hA5C7, 4'd0, 4'd10, -1, 1'b0, "R9");
    endtask

    task automatic t_window();
        launch(16'h1234, 4'd3, 4'd12);
        stream(16'h1234, 4'd3, 4'd12, -1, 1'b0, "R6");
        launch(16'h00F0, 4'd9, 4'd4);
        stream(16'h00F0, 4'd9, 4'd4, -1, 1'b0, "R6");
    endtask

    task automatic t_start_midrun();
        launch(16'h0F0F, 4'd2, 4'd13);
        stream(16'h0F0F, 4'd2, 4'd13, 5, 1'b0, "R8");
    endtask

    task automatic t_start_last_beat();
        launch(16'h3C5A, 4'd2, 4'd9);
        stream(16'h3C5A, 4'd2, 4'd9, RUNL - 1, 1'b0, "R8");
    endtask

    task automatic t_restart_in_done();
        launch(16'h7E81, 4'd1, 4'd14);
        stream(16'h7E81, 4'd1, 4'd14, -1, 1'b1, "R10");
        launch(16'hBEEF, 4'd0, 4'd7);
        chk(addr_vld == 1'b1, "R10", {15'b0, addr_vld}, 16'h1);
        stream(16'hBEEF, 4'd0, 4'd7, -1, 1'b0, "R10");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full_range();
        t_upper_limit();
        t_window();
        t_start_midrun();
        t_start_last_beat();
        t_restart_in_done();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule